// File: doc/BRIEF.md
# Multi-Line Clock Timing Qualifier

This block times a set of clock lines that arrive as one-bit comparator outputs, with each comparator threshold held at the middle of its clock's swing. Each line is sampled on the system clock, which runs at 100 MHz in the intended use, so one count is one 10 ns tick. After a start strobe the block opens a measurement window. For every line it measures the first high phase, the low phase that follows, and the full period. It also stamps the tick at which the line's first rising edge arrived.

The window closes when every line has shown two rising edges, or when a programmable tick limit runs out. A done flag then rises, and any line that never toggled is flagged as stuck. A host reads the results one field at a time through a small select-and-read port. It recovers the order of the rising edges across the lines by comparing their timestamps. Limit checking and threshold control belong to the surrounding logic.

Top module: `clk_timing_qual`

## Requirements
- R1: After reset, busy, done, every stuck bit and rd_data are all 0.
- R2: A start pulse sets busy and clears done on the next edge. It also clears every channel's stored results, so results from an earlier window cannot be read afterwards.
- R3: A channel's high time equals the number of clock cycles its input stays 1 after its first rising edge in the window (field code 0).
- R4: A channel's low time equals the number of cycles its input stays 0 after that first high phase ends (field code 1).
- R5: A channel's period equals the number of cycles from its first to its second rising edge in the window (field code 2).
- R6: The timestamp (field code 3) holds the window tick of the channel's first rising edge. The difference between two channels' timestamps equals the delay in cycles between their rising edges.
- R7: When all channels have seen two rising edges, the window closes on its own: done goes to 1, busy goes to 0, and done stays high until the next start.
- R8: If not every channel completes, the window closes after timeout_cyc cycles of busy and done rises.
- R9: A channel that shows no transition in the window has its stuck bit set at close, and all four of its fields read 0.
- R10: Every count saturates at 2^CW-1 instead of wrapping.
- R11: rd_data presents the field chosen by rd_fld for channel rd_ch one cycle after the selection is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle strobe that arms a new window |
| timeout_cyc | input | TOW | Window length limit in cycles |
| cmp_in | input | NCH | Comparator outputs, one per line |
| rd_ch | input | CHW | Channel to read |
| rd_fld | input | 2 | Field to read: 0 high, 1 low, 2 period, 3 timestamp |
| busy | output | 1 | Window open |
| done | output | 1 | Window closed, results valid |
| stuck | output | NCH | Lines with no transition in the last window |
| rd_data | output | CW | Registered read data |

## Verification
Host reads and counting can fall in the same cycle, and so can the close of the window and the final updates of the channels. The bench makes the lines finish in a staggered order so that the last update to a channel lands right next to the automatic close. It then reads every field only after done, checks that the values match the drive pattern exactly, and checks that the ordering deltas agree. A second window, with one line held quiet, forces a close on the time limit while the other lines are still active. This shows that the stuck marking and the zeroed fields agree with each other.

// File: rtl/qual_pkg.sv
package qual_pkg;
    typedef enum logic [1:0] {
        CH_WAIT = 2'd0,
        CH_HIGH = 2'd1,
        CH_LOW  = 2'd2,
        CH_FIN  = 2'd3
    } ch_state_e;

    localparam logic [1:0] FLD_HIGH = 2'd0;
    localparam logic [1:0] FLD_LOW  = 2'd1;
    localparam logic [1:0] FLD_PER  = 2'd2;
    localparam logic [1:0] FLD_TS   = 2'd3;
endpackage

// File: rtl/qual_sync.sv
module qual_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    for (genvar i = 0; i < W; i++) begin : g_line
        logic s1_q, s2_q, prev_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1_q   <= 1'b0;
                s2_q   <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                s1_q   <= din[i];
                s2_q   <= s1_q;
                prev_q <= s2_q;
            end
        end
        assign rise[i] = s2_q & ~prev_q;
        assign fall[i] = ~s2_q & prev_q;
    end
endmodule

// File: rtl/qual_chan.sv
module qual_chan
    import qual_pkg::*;
#(
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic          en,
    input  logic          rise,
    input  logic          fall,
    input  logic [CW-1:0] now,
    output logic [CW-1:0] hi_cnt,
    output logic [CW-1:0] lo_cnt,
    output logic [CW-1:0] per_cnt,
    output logic [CW-1:0] ts,
    output logic          fin,
    output logic          seen
);
    typedef struct packed {
        ch_state_e     st;
        logic [CW-1:0] hi;
        logic [CW-1:0] lo;
        logic [CW-1:0] per;
        logic [CW-1:0] ts;
        logic          seen;
    } chan_t;

    chan_t q, d;

    function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] x);
        return (x == '1) ? x : x + 1'b1;
    endfunction

    always_comb begin
        d = q;
        if (arm) begin
            d = '0;
            d.st = CH_WAIT;
        end else if (en) begin
            if (rise || fall) d.seen = 1'b1;
            unique case (q.st)
                CH_WAIT: if (rise) begin
                    d.st  = CH_HIGH;
                    d.ts  = now;
                    d.hi  = 1;
                    d.per = 1;
                end
                CH_HIGH: begin
                    d.per = sat_inc(q.per);
                    if (fall) begin
                        d.st = CH_LOW;
                        d.lo = 1;
                    end else begin
                        d.hi = sat_inc(q.hi);
                    end
                end
                CH_LOW: begin
                    if (rise) begin
                        d.st = CH_FIN;
                    end else begin
                        d.lo  = sat_inc(q.lo);
                        d.per = sat_inc(q.per);
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign hi_cnt  = q.hi;
    assign lo_cnt  = q.lo;
    assign per_cnt = q.per;
    assign ts      = q.ts;
    assign fin     = (q.st == CH_FIN);
    assign seen    = q.seen;
endmodule

// File: rtl/clk_timing_qual.sv
module clk_timing_qual
    import qual_pkg::*;
#(
    parameter int NCH = 16,
    parameter int CW  = 24,
    parameter int TOW = 24,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [TOW-1:0] timeout_cyc,
    input  logic [NCH-1:0] cmp_in,
    input  logic [CHW-1:0] rd_ch,
    input  logic [1:0]     rd_fld,
    output logic           busy,
    output logic           done,
    output logic [NCH-1:0] stuck,
    output logic [CW-1:0]  rd_data
);
    localparam int XW = TOW + CW;

    typedef struct packed {
        logic           busy;
        logic           done;
        logic [TOW-1:0] timer;
        logic [NCH-1:0] stuck;
        logic [CW-1:0]  rd_data;
    } top_t;

    top_t q, d;

    logic [NCH-1:0]         rise_v, fall_v, fin_v, seen_v;
    logic [NCH-1:0][CW-1:0] hi_v, lo_v, per_v, ts_v;
    logic [CW-1:0]          now_ts;
    logic [XW-1:0]          timer_x;
    logic                   win_end;

    qual_sync #(.W(NCH)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (cmp_in),
        .rise (rise_v),
        .fall (fall_v)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        qual_chan #(.CW(CW)) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .arm    (start),
            .en     (q.busy),
            .rise   (rise_v[i]),
            .fall   (fall_v[i]),
            .now    (now_ts),
            .hi_cnt (hi_v[i]),
            .lo_cnt (lo_v[i]),
            .per_cnt(per_v[i]),
            .ts     (ts_v[i]),
            .fin    (fin_v[i]),
            .seen   (seen_v[i])
        );
    end

    always_comb begin
        timer_x = XW'(q.timer);
        now_ts  = (timer_x > XW'({CW{1'b1}})) ? '1 : timer_x[CW-1:0];
        win_end = ((TOW+1)'(q.timer) + (TOW+1)'(1)) >= (TOW+1)'(timeout_cyc);
    end

    always_comb begin
        d = q;
        if (start) begin
            d.busy  = 1'b1;
            d.done  = 1'b0;
            d.timer = '0;
            d.stuck = '0;
        end else if (q.busy) begin
            d.timer = (q.timer == '1) ? q.timer : q.timer + 1'b1;
            if ((&fin_v) || win_end) begin
                d.busy  = 1'b0;
                d.done  = 1'b1;
                d.stuck = ~seen_v;
            end
        end
        d.rd_data = '0;
        if (32'(rd_ch) < NCH) begin
            unique case (rd_fld)
                FLD_HIGH: d.rd_data = hi_v[rd_ch];
                FLD_LOW:  d.rd_data = lo_v[rd_ch];
                FLD_PER:  d.rd_data = per_v[rd_ch];
                default:  d.rd_data = ts_v[rd_ch];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy    = q.busy;
    assign done    = q.done;
    assign stuck   = q.stuck;
    assign rd_data = q.rd_data;
endmodule

// File: rtl/clk_timing_qual_chk.sv
module clk_timing_qual_chk #(
    parameter int NCH = 16,
    parameter int CW  = 24
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start,
    input logic                   busy,
    input logic                   done,
    input logic [NCH-1:0]         stuck,
    input logic [NCH-1:0]         fin_v,
    input logic [NCH-1:0][CW-1:0] hi_v,
    input logic [NCH-1:0][CW-1:0] lo_v,
    input logic [NCH-1:0][CW-1:0] per_v
);
    // R2
    arm_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (busy && !done));

    // R7
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R7
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    for (genvar i = 0; i < NCH; i++) begin : g_c
        // R5
        period_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (fin_v[i] && (per_v[i] != {CW{1'b1}})) |->
                ({1'b0, per_v[i]} == ({1'b0, hi_v[i]} + {1'b0, lo_v[i]})));

        // R9
        stuck_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            stuck[i] |-> (hi_v[i] == '0 && lo_v[i] == '0 && per_v[i] == '0));
    end
endmodule

bind clk_timing_qual clk_timing_qual_chk #(.NCH(NCH), .CW(CW)) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .start(start),
    .busy (busy),
    .done (done),
    .stuck(stuck),
    .fin_v(fin_v),
    .hi_v (hi_v),
    .lo_v (lo_v),
    .per_v(per_v)
);

// File: tb/clk_timing_qual_test.sv
module clk_timing_qual_test;
    localparam int NCH = 4;
    localparam int CW  = 10;
    localparam int TOW = 16;
    localparam int SAT = (1 << CW) - 1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [TOW-1:0] timeout_cyc = '0;
    logic [NCH-1:0] cmp_in = '0;
    logic [1:0]     rd_ch = '0;
    logic [1:0]     rd_fld = '0;
    logic           busy, done;
    logic [NCH-1:0] stuck;
    logic [CW-1:0]  rd_data;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    typedef struct {
        int    ch;
        int    fld;
        int    val;
        bit    rel;
        bit    base;
        string req;
    } item_t;

    item_t exp_q[$];
    bit    mon_busy = 0;
    int    base_ts = 0;

    always #2 clk = ~clk;

    clk_timing_qual #(.NCH(NCH), .CW(CW), .TOW(TOW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .timeout_cyc(timeout_cyc),
        .cmp_in(cmp_in), .rd_ch(rd_ch), .rd_fld(rd_fld),
        .busy(busy), .done(done), .stuck(stuck), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push(input int ch, input int fld, input int val,
                        input bit rel, input bit base, input string req);
        item_t it;
        it.ch = ch; it.fld = fld; it.val = val;
        it.rel = rel; it.base = base; it.req = req;
        exp_q.push_back(it);
    endtask

    // monitor: pops expected items, reads the field, compares
    initial begin
        forever begin
            item_t it;
            int got, cmpv;
            wait (exp_q.size() > 0);
            mon_busy = 1;
            it = exp_q.pop_front();
            @(negedge clk);
            rd_ch  = 2'(it.ch);
            rd_fld = 2'(it.fld);
            @(negedge clk);
            got = int'(rd_data);
            if (it.base) base_ts = got;
            cmpv = it.rel ? got - base_ts : got;
            chk(cmpv == it.val, it.req, cmpv, it.val);
            mon_busy = 0;
        end
    end

    task automatic drain();
        wait (exp_q.size() == 0 && !mon_busy);
    endtask

    task automatic wave(input int ch, input int dly, input int h, input int l);
        repeat (dly) @(negedge clk);
        cmp_in[ch] = 1'b1;
        repeat (h) @(negedge clk);
        cmp_in[ch] = 1'b0;
        repeat (l) @(negedge clk);
        cmp_in[ch] = 1'b1;
        repeat (20) @(negedge clk);
        cmp_in[ch] = 1'b0;
    endtask

    task automatic arm(input int tmo);
        @(negedge clk);
        timeout_cyc = TOW'(tmo);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy && !done, "R2 busy after start", int'(busy), 1);
    endtask

    task automatic wait_done(input int lim, input string req);
        for (int k = 0; k < lim; k++) begin
            if (done) break;
            @(negedge clk);
        end
        chk(done, req, int'(done), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy && !done, "R1 busy/done", int'({busy, done}), 0);
        chk(stuck == '0, "R1 stuck", int'(stuck), 0);
        chk(rd_data == '0, "R1 rd_data", int'(rd_data), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Window 1: all lines complete, staggered
        arm(500);
        fork
            wave(0, 5, 7, 9);
            wave(1, 12, 3, 4);
            wave(2, 8, 15, 2);
            wave(3, 20, 1, 1);
        join
        wait_done(100, "R7 auto close");
        chk(!busy, "R7 busy low at done", int'(busy), 0);
        chk(stuck == '0, "R9 no stuck when all toggle", int'(stuck), 0);
        push(0, 0, 7, 0, 0, "R3 ch0 high");
        push(0, 1, 9, 0, 0, "R4 ch0 low");
        push(0, 2, 16, 0, 0, "R5 ch0 period");
        push(1, 0, 3, 0, 0, "R3 ch1 high");
        push(1, 1, 4, 0, 0, "R4 ch1 low");
        push(1, 2, 7, 0, 0, "R5 ch1 period");
        push(2, 2, 17, 0, 0, "R5 ch2 period");
        push(3, 0, 1, 0, 0, "R3 ch3 one-cycle high");
        push(3, 1, 1, 0, 0, "R4 ch3 one-cycle low");
        push(0, 3, 0, 1, 1, "R6 ch0 timestamp base");
        push(1, 3, 7, 1, 0, "R6 ch1 order delta");
        push(2, 3, 3, 1, 0, "R6 ch2 order delta");
        push(3, 3, 15, 1, 0, "R6 ch3 order delta");
        drain();
        repeat (5) @(negedge clk);
        chk(done, "R7 done held", int'(done), 1);

        // Window 2: ch2 quiet, close on timeout
        arm(300);
        fork
            wave(0, 5, 7, 9);
            wave(1, 6, 3, 4);
            wave(3, 9, 2, 2);
        join
        repeat (200) @(negedge clk);
        chk(busy && !done, "R8 still open before limit", int'(busy), 1);
        wait_done(100, "R8 timeout close");
        chk(stuck == 4'b0100, "R9 stuck bit ch2", int'(stuck), 4);
        push(2, 0, 0, 0, 0, "R9 ch2 high zero");
        push(2, 1, 0, 0, 0, "R9 ch2 low zero");
        push(2, 2, 0, 0, 0, "R2 R9 ch2 period cleared");
        push(2, 3, 0, 0, 0, "R9 ch2 timestamp zero");
        push(1, 2, 7, 0, 0, "R8 ch1 period kept");
        drain();

        // Window 3: saturation
        arm(4000);
        fork
            wave(0, 5, 1100, 50);
            wave(1, 6, 1100, 50);
            wave(2, 7, 1100, 50);
            wave(3, 8, 1100, 50);
        join
        wait_done(100, "R7 close after long pulses");
        push(0, 0, SAT, 0, 0, "R10 high saturates");
        push(0, 1, 50, 0, 0, "R4 low after saturated high");
        push(0, 2, SAT, 0, 0, "R10 period saturates");
        push(0, 3, 0, 1, 1, "R6 base");
        push(3, 3, 3, 1, 0, "R11 R6 ch3 read delta");
        drain();

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule